// File: doc/BRIEF.md
# Dual-Reference Selection and Alarm Controller

This block is the digital supervisor of a clock synchroniser that can follow one of two slow reference clocks. Running on a fast local system clock, it watches each reference for rising edges and declares it active or inactive. It then combines the reference activity with a select input, a force input and a functional reset to pick one of four operating modes: locked to A, locked to B, unstable, or free run.

From the mode it drives three outputs:

- a free-run status flag;
- a single alarm that merges loss of reference with a loss-of-lock indication coming from an external phase detector;
- a gated complementary output pair, which can be parked in a fixed state by an active-high disable.

After any entry into a locked mode, the loss-of-lock contribution to the alarm is suppressed for a qualification window. This keeps a reference switch from raising a spurious alarm while the loop settles.

Top module: `refsel_supervisor`

## Requirements
- R1: `sel_b` = 0 selects reference A and `sel_b` = 1 selects reference B. `mode_o` is encoded 0 = free run, 1 = locked to A, 2 = locked to B, 3 = unstable.
- R2: While `sup_reset` is 1, the block is in free run (`mode_o` = 0) with `fr_status` = 1 from the next cycle on, whatever the references do.
- R3: While `force_fr` is 1, the block is in free run with `fr_status` = 1 from the next cycle on, even if both references are active.
- R4: When neither reference is active, the block enters free run by itself, with `fr_status` = 1 and `alarm` = 1. This holds for either value of `sel_b`.
- R5: When the selected reference is active, the block is locked to it, with `alarm` = 0 (loss of lock absent) and `fr_status` = 0, whatever the other reference does.
- R6: When the selected reference is inactive and the other is active, `mode_o` = 3, `alarm` = 1 and `fr_status` = 0. The block stays in this mode and never moves to the other reference on its own.
- R7: A reference is inactive from system reset until it shows rising edges. It becomes inactive again when no rising edge arrives for ACT_TIMEOUT system-clock cycles, and becomes active again once edges return. Each reference passes through a two-flop synchroniser before edge detection.
- R8: In a locked mode outside the qualification window, `alarm` follows `lol_in` one cycle later: the alarm is the OR of loss of reference and loss of lock.
- R9: Each entry into a locked mode from any other mode masks `lol_in` from the alarm for BLANK_CYC cycles.
- R10: When `out_dis` = 1, `clk_q` = 0 and `clk_qn` = 1. When `out_dis` = 0, `clk_q` = `osc_in` and `clk_qn` = NOT `osc_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| sup_reset | input | 1 | Functional reset, forces free run (active high) |
| force_fr | input | 1 | Force free run (active high) |
| sel_b | input | 1 | Reference select: 0 = A, 1 = B |
| ref_a | input | 1 | Reference clock A, asynchronous |
| ref_b | input | 1 | Reference clock B, asynchronous |
| lol_in | input | 1 | Loss-of-lock indication from the phase detector |
| out_dis | input | 1 | Output disable (active high) |
| osc_in | input | 1 | Oscillator signal to be gated onto the pair |
| fr_status | output | 1 | Free-run status |
| alarm | output | 1 | Combined loss-of-reference / loss-of-lock alarm |
| mode_o | output | 2 | Current mode code |
| clk_q | output | 1 | True output of the pair |
| clk_qn | output | 1 | Complement output of the pair |

## Verification
The bench drives the references as toggling clocks and silences them one at a time, then both, and walks every row of the mode table.

- **Unstable mode.** It holds the unstable mode for far longer than the timeout. A design that hunted for the good reference would show up as a locked code where 3 is expected.
- **Loss-of-lock masking.** It raises loss of lock while locked and then switches reference with loss of lock still high. A missing mask shows as an alarm inside the window, and a mask that never expires shows as a silent alarm after it.
- **Free run with a changing select.** It toggles the select while both references are dead. A design that left free run on a select change would fail the free-run check.
- **Disabled pair.** It checks the output pair against the oscillator with the disable in both states.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  typedef enum logic [1:0] {
    MD_FREE     = 2'd0,
    MD_LOCK_A   = 2'd1,
    MD_LOCK_B   = 2'd2,
    MD_UNSTABLE = 2'd3
  } mode_e;
endpackage

// File: rtl/ref_act_mon.sv
// Activity monitor for one slow asynchronous reference.
module ref_act_mon #(
  parameter int TIMEOUT_CYC = 2200,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_i,
  output logic active_o
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

  logic [SYNC_STAGES:0] sh_q;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic                 act_q, act_d;
  logic                 rise;

  // synchroniser stages plus one extra stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SYNC_STAGES-1:0], ref_i};
  end

  assign rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (rise) begin
      cnt_d = '0;
      act_d = 1'b1;
    end else if (cnt_q == LIMIT) begin
      act_d = 1'b0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= LIMIT;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/blank_timer.sv
// Qualification window: loaded on a switch, active while non-zero.
module blank_timer #(
  parameter int WIN_CYC = 4000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic active_o
);
  localparam int CW = $clog2(WIN_CYC + 1);
  localparam logic [CW-1:0] WIN = CW'(WIN_CYC);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load_i)           cnt_d = WIN;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    else                  cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/refsel_mode_ctl.sv
// Mode decision and alarm composition.
module refsel_mode_ctl
  import refsel_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sup_reset,
  input  logic        force_fr,
  input  logic        sel_b,
  input  logic        act_a,
  input  logic        act_b,
  input  logic        lol_in,
  input  logic        blank_act,
  output logic        switch_o,
  output logic [1:0]  mode_o,
  output logic        fr_o,
  output logic        alarm_o
);
  mode_e mode_q, mode_d;
  logic  fr_q, fr_d, alarm_q, alarm_d;
  logic  act_sel, act_oth, locked_d, lol_mask, lor_d;

  assign act_sel = sel_b ? act_b : act_a;
  assign act_oth = sel_b ? act_a : act_b;

  always_comb begin
    if (sup_reset || force_fr)  mode_d = MD_FREE;
    else if (act_sel)           mode_d = sel_b ? MD_LOCK_B : MD_LOCK_A;
    else if (act_oth)           mode_d = MD_UNSTABLE;
    else                        mode_d = MD_FREE;
  end

  assign locked_d = (mode_d == MD_LOCK_A) || (mode_d == MD_LOCK_B);
  assign switch_o = locked_d && (mode_d != mode_q);
  assign lol_mask = blank_act | switch_o;
  assign lor_d    = (mode_d == MD_UNSTABLE) ||
                    ((mode_d == MD_FREE) && !act_a && !act_b);

  always_comb begin
    fr_d    = (mode_d == MD_FREE);
    alarm_d = lor_d | (locked_d & lol_in & ~lol_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MD_FREE;
      fr_q    <= 1'b1;
      alarm_q <= 1'b1;
    end else begin
      mode_q  <= mode_d;
      fr_q    <= fr_d;
      alarm_q <= alarm_d;
    end
  end

  assign mode_o  = mode_q;
  assign fr_o    = fr_q;
  assign alarm_o = alarm_q;
endmodule

// File: rtl/refsel_supervisor.sv
module refsel_supervisor #(
  parameter int ACT_TIMEOUT = 2200,
  parameter int BLANK_CYC   = 4000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sup_reset,
  input  logic       force_fr,
  input  logic       sel_b,
  input  logic       ref_a,
  input  logic       ref_b,
  input  logic       lol_in,
  input  logic       out_dis,
  input  logic       osc_in,
  output logic       fr_status,
  output logic       alarm,
  output logic [1:0] mode_o,
  output logic       clk_q,
  output logic       clk_qn
);
  localparam int NREF = 2;

  logic [NREF-1:0] ref_vec, act_vec;
  logic            blank_act, switch_p;

  assign ref_vec = {ref_b, ref_a};

  for (genvar g = 0; g < NREF; g++) begin : g_mon
    ref_act_mon #(.TIMEOUT_CYC(ACT_TIMEOUT), .SYNC_STAGES(2)) u_mon (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_i    (ref_vec[g]),
      .active_o (act_vec[g])
    );
  end

  blank_timer #(.WIN_CYC(BLANK_CYC)) u_blank (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (switch_p),
    .active_o (blank_act)
  );

  refsel_mode_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sup_reset (sup_reset),
    .force_fr  (force_fr),
    .sel_b     (sel_b),
    .act_a     (act_vec[0]),
    .act_b     (act_vec[1]),
    .lol_in    (lol_in),
    .blank_act (blank_act),
    .switch_o  (switch_p),
    .mode_o    (mode_o),
    .fr_o      (fr_status),
    .alarm_o   (alarm)
  );

  assign clk_q  = ~out_dis & osc_in;
  assign clk_qn =  out_dis | ~osc_in;
endmodule

// File: rtl/refsel_supervisor_chk.sv
module refsel_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sup_reset,
  input logic       force_fr,
  input logic       out_dis,
  input logic       fr_status,
  input logic       alarm,
  input logic [1:0] mode_o,
  input logic       clk_q,
  input logic       clk_qn
);
  AST_RESET_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    sup_reset |=> fr_status); // R2
  AST_FORCE_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    force_fr |=> (fr_status && mode_o == 2'd0)); // R3
  AST_UNSTABLE_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd3) |-> (alarm && !fr_status)); // R6
  AST_SWITCH_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mode_o) && (mode_o == 2'd1 || mode_o == 2'd2)) |-> !alarm); // R9
  AST_PAIR_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    out_dis |-> (!clk_q && clk_qn)); // R10
endmodule

bind refsel_supervisor refsel_supervisor_chk u_chk (.*);

// File: tb/sim_refsel_supervisor.sv
`timescale 1ns/1ps
module sim_refsel_supervisor;
  localparam int TO  = 40;
  localparam int WIN = 64;

  logic clk = 1'b0;
  logic rst_n, sup_reset, force_fr, sel_b, ref_a, ref_b, lol_in, out_dis, osc_in;
  logic fr_status, alarm, clk_q, clk_qn;
  logic [1:0] mode_o;
  logic en_a, en_b;

  typedef struct {
    bit         pair;
    logic [1:0] mode;
    logic       fr;
    logic       al;
    logic       q;
    logic       qn;
    string      req;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  refsel_supervisor #(.ACT_TIMEOUT(TO), .BLANK_CYC(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .sup_reset(sup_reset), .force_fr(force_fr),
    .sel_b(sel_b), .ref_a(ref_a), .ref_b(ref_b), .lol_in(lol_in),
    .out_dis(out_dis), .osc_in(osc_in), .fr_status(fr_status),
    .alarm(alarm), .mode_o(mode_o), .clk_q(clk_q), .clk_qn(clk_qn)
  );

  // reference generators: edge every 16 cycles while enabled
  initial begin
    ref_a = 1'b0;
    forever begin
      repeat (8) @(negedge clk);
      ref_a = en_a ? ~ref_a : 1'b0;
    end
  end
  initial begin
    ref_b = 1'b0;
    forever begin
      repeat (5) @(negedge clk);
      repeat (3) @(negedge clk);
      ref_b = en_b ? ~ref_b : 1'b0;
    end
  end

  // monitor: compares one queued expectation per cycle after the edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (it.pair) begin
        if (clk_q !== it.q || clk_qn !== it.qn) begin
          errors++;
          $display("FAIL %s pair q/qn=%b%b expected %b%b", it.req, clk_q, clk_qn, it.q, it.qn);
        end
      end else if (mode_o !== it.mode || fr_status !== it.fr || alarm !== it.al) begin
        errors++;
        $display("FAIL %s mode/fr/alarm=%0d/%b/%b expected %0d/%b/%b",
                 it.req, mode_o, fr_status, alarm, it.mode, it.fr, it.al);
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic exp_state(input logic [1:0] m, input logic f, input logic a, input string r);
    item_t it;
    it.pair = 1'b0; it.mode = m; it.fr = f; it.al = a; it.q = 1'b0; it.qn = 1'b0; it.req = r;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic exp_pair(input logic dis, input logic osc, input string r);
    item_t it;
    out_dis = dis; osc_in = osc;
    it.pair = 1'b1; it.mode = 2'd0; it.fr = 1'b0; it.al = 1'b0;
    it.q = ~dis & osc; it.qn = dis | ~osc; it.req = r;
    sb.push_back(it);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sup_reset = 1'b0; force_fr = 1'b0; sel_b = 1'b0;
    lol_in = 1'b0; out_dis = 1'b0; osc_in = 1'b0; en_a = 1'b0; en_b = 1'b0;
    wait_cyc(6);
    rst_n = 1'b1;
    wait_cyc(5);
    exp_state(2'd0, 1'b1, 1'b1, "R7 reset: no reference active, R4 free run");

    en_a = 1'b1; en_b = 1'b1;
    wait_cyc(80);
    exp_state(2'd1, 1'b0, 1'b0, "R1 R5 sel 0 locks to A");
    sel_b = 1'b1;
    wait_cyc(10);
    exp_state(2'd2, 1'b0, 1'b0, "R1 R5 sel 1 locks to B");
    sel_b = 1'b0;
    wait_cyc(100);

    lol_in = 1'b1;
    wait_cyc(4);
    exp_state(2'd1, 1'b0, 1'b1, "R8 loss of lock raises alarm");
    sel_b = 1'b1;
    wait_cyc(10);
    exp_state(2'd2, 1'b0, 1'b0, "R9 loss of lock masked after switch");
    wait_cyc(70);
    exp_state(2'd2, 1'b0, 1'b1, "R9 mask expired");
    lol_in = 1'b0;
    wait_cyc(4);
    exp_state(2'd2, 1'b0, 1'b0, "R8 alarm clears with lock");

    en_b = 1'b0;
    wait_cyc(90);
    exp_state(2'd3, 1'b0, 1'b1, "R6 R7 selected B lost, A good: unstable");
    wait_cyc(300);
    exp_state(2'd3, 1'b0, 1'b1, "R6 no switch on its own");
    sel_b = 1'b0;
    wait_cyc(10);
    exp_state(2'd1, 1'b0, 1'b0, "R5 locked to A with B dead");

    sup_reset = 1'b1;
    wait_cyc(3);
    exp_state(2'd0, 1'b1, 1'b0, "R2 functional reset forces free run");
    sup_reset = 1'b0;
    wait_cyc(5);
    exp_state(2'd1, 1'b0, 1'b0, "R2 release returns to lock");

    force_fr = 1'b1;
    wait_cyc(3);
    exp_state(2'd0, 1'b1, 1'b0, "R3 forced free run");
    force_fr = 1'b0;
    wait_cyc(5);

    en_a = 1'b0;
    wait_cyc(90);
    exp_state(2'd0, 1'b1, 1'b1, "R4 both lost: free run with alarm");
    sel_b = 1'b1;
    wait_cyc(5);
    exp_state(2'd0, 1'b1, 1'b1, "R4 free run with sel 1");

    en_b = 1'b1;
    wait_cyc(80);
    exp_state(2'd2, 1'b0, 1'b0, "R7 B recovers, locks to B");

    exp_pair(1'b0, 1'b1, "R10 enabled osc 1");
    exp_pair(1'b0, 1'b0, "R10 enabled osc 0");
    exp_pair(1'b1, 1'b1, "R10 disabled osc 1");
    exp_pair(1'b1, 1'b0, "R10 disabled osc 0");

    wait_cyc(3);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule